// File: doc/BRIEF.md
# Request/Acknowledge Handshake Checker

This block watches a single-bit request/acknowledge pair and reports protocol faults. It classifies five kinds of fault: a repeated request, an orphan acknowledge, a duplicate acknowledge, an early acknowledge and a late acknowledge. Each fault class has its own bit in a sticky error register, and that bit stays set until reset. A one-cycle strobe marks every cycle in which at least one fault was seen. A third output shows whether a request is still waiting for its acknowledge. The smallest and largest allowed acknowledge delays are parameters.

A request begins on a rising edge of `req`, which is found by comparing `req` with a registered copy of itself. The acknowledge delay is the number of clock cycles from the cycle of that rising edge to the cycle in which `ack` is high, so an acknowledge in the same cycle as the edge has delay 0. The input `ack` is read as a level: every cycle in which it is high counts as one acknowledge.

The tracker has three states:
- `ST_IDLE`: no request is known.
- `ST_WAIT`: a request is outstanding, and a delay counter holds the delay of the current cycle.
- `ST_DONE`: the request has been acknowledged and `req` has not yet been seen low.

The transitions are:
- `ST_IDLE`/`ST_DONE` → `ST_WAIT` on a request edge with no acknowledge.
- `ST_IDLE`/`ST_DONE` → `ST_DONE` on a request edge with an acknowledge in the same cycle.
- `ST_DONE` → `ST_IDLE` when `req` is low.
- `ST_WAIT` → `ST_DONE` on an acknowledge within the limit.
- `ST_WAIT` → `ST_IDLE` on a timeout.
- `ST_WAIT` → `ST_WAIT` with the counter restarted on a repeated request edge.

Top module: `reqack_monitor`

## Requirements
- R1: While `rst_n` is low, and at the first clock edge after reset, `err_flags`, `err_pulse` and `pending` are all 0.
- R2: In a cycle where `req` is 1 and was 0 in the cycle before, with `ack` low, `pending` is 1 after that clock edge and stays 1 until the request is acknowledged or times out.
- R3: An acknowledge with delay d, where MIN_ACK <= d <= MAX_ACK, sets no error bit and drops `pending` after its edge.
- R4: A request edge seen while `pending` is 1 sets bit 0 (repeated request).
- R5: An acknowledge while the checker is idle, with no request edge in the same cycle, sets bit 1 (orphan acknowledge). The checker is idle when no request is pending and the last request is not in its acknowledged-and-high phase.
- R6: After a request has been acknowledged, a further acknowledge sets bit 2 (duplicate acknowledge). This holds in any cycle up to and including the first cycle in which `req` is low, and only when no new request edge arrives in that cycle.
- R7: An acknowledge with delay d < MIN_ACK sets bit 3 (early acknowledge). This includes delay 0, an acknowledge in the same cycle as the request edge, when MIN_ACK >= 1.
- R8: If no acknowledge has come by delay MAX_ACK, then in the cycle of delay MAX_ACK+1 bit 4 is set (late acknowledge) and `pending` drops. An acknowledge in that same cycle is late as well.
- R9: Every bit of `err_flags` stays set until reset.
- R10: `err_pulse` is 1 for exactly those clock periods that follow a cycle in which at least one violation was detected.
- R11: A repeated request edge restarts timing, so that the new request is pending with its delay counted from that edge.
- R12: All error bits and the strobe change at the clock edge that closes the offending cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request level from the observed interface |
| ack | input | 1 | Acknowledge level; each high cycle counts as one acknowledge |
| err_flags | output | 5 | Sticky fault bits: 0 repeat, 1 orphan, 2 duplicate, 3 early, 4 late |
| err_pulse | output | 1 | High for one period after each cycle with a fault |
| pending | output | 1 | A request is outstanding and unacknowledged |

## Verification
Every result of this checker is registered once. The error bits, the strobe and `pending` for a given pair of `req` and `ack` values are all due at the very edge that samples those values. The bench drives inputs on the falling edge, updates its reference model at the rising edge, and compares one time unit later, so each comparison sees exactly one cycle of stimulus. The late case is checked against the delay count, which rises to MAX_ACK+1 four cycles after the request edge with the default limits.

// File: rtl/reqack_pkg.sv
`timescale 1ns/1ps
package reqack_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } hs_state_e;

    localparam int NUM_VIOL  = 5;
    localparam int V_REPEAT  = 0;
    localparam int V_ORPHAN  = 1;
    localparam int V_DUP     = 2;
    localparam int V_EARLY   = 3;
    localparam int V_LATE    = 4;
endpackage

// File: rtl/reqack_edge.sv
`timescale 1ns/1ps
module reqack_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic req_rise
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req;
    end

    assign req_rise = req & ~req_q;

    // R2: a detected edge means req was low one cycle earlier
    a_r2_rise_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        req_rise |-> !$past(req));
endmodule

// File: rtl/reqack_fsm.sv
`timescale 1ns/1ps
module reqack_fsm
    import reqack_pkg::*;
#(
    parameter int MIN_ACK = 1,
    parameter int MAX_ACK = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                ack,
    input  logic                req_rise,
    output logic [NUM_VIOL-1:0] det,
    output logic                pending
);
    localparam int CW = $clog2(MAX_ACK + 2);
    localparam logic [CW-1:0] LIM_HI = CW'(MAX_ACK);
    localparam logic [CW-1:0] LIM_LO = CW'(MIN_ACK);
    localparam logic [CW-1:0] ONE    = CW'(1);

    hs_state_e      state, state_nxt;
    logic [CW-1:0]  cnt, cnt_nxt;
    logic           too_late, too_early;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    assign too_late  = (cnt > LIM_HI);
    assign too_early = (cnt < LIM_LO);

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        det       = '0;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (req_rise) begin
                    if (ack) begin
                        det[V_EARLY] = (MIN_ACK > 0);
                        state_nxt    = ST_DONE;
                    end else begin
                        state_nxt = ST_WAIT;
                        cnt_nxt   = ONE;
                    end
                end else begin
                    if (ack) begin
                        if (state == ST_IDLE) det[V_ORPHAN] = 1'b1;
                        else                  det[V_DUP]    = 1'b1;
                    end
                    if (state == ST_DONE && !req) state_nxt = ST_IDLE;
                end
            end
            ST_WAIT: begin
                if (ack) begin
                    if (too_late)       det[V_LATE]  = 1'b1;
                    else if (too_early) det[V_EARLY] = 1'b1;
                    state_nxt = too_late ? ST_IDLE : ST_DONE;
                end else if (too_late) begin
                    det[V_LATE] = 1'b1;
                    state_nxt   = ST_IDLE;
                end else begin
                    cnt_nxt = cnt + ONE;
                end
                if (req_rise) begin
                    det[V_REPEAT] = 1'b1;
                    state_nxt     = ST_WAIT;
                    cnt_nxt       = ONE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    assign pending = (state == ST_WAIT);

    // R8: the delay count never runs beyond one past the upper limit
    a_r8_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> (cnt >= ONE && cnt <= LIM_HI + ONE));
    // R8: a timeout without a new request edge leaves nothing outstanding
    a_r8_late_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack && too_late && !req_rise) |=> !pending);
    // R11: a repeated edge keeps the request outstanding with a fresh count
    a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && req_rise) |=> (pending && cnt == ONE));
endmodule

// File: rtl/reqack_collect.sv
`timescale 1ns/1ps
module reqack_collect
    import reqack_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_VIOL-1:0] det,
    output logic [NUM_VIOL-1:0] flags_q,
    output logic                pulse_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            pulse_q <= 1'b0;
        end else begin
            flags_q <= flags_q | det;
            pulse_q <= |det;
        end
    end

    // R9: no flag that is set ever clears while out of reset
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q != '0) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
    // R10: the strobe never appears without a recorded fault
    a_r10_pulse_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (flags_q != '0));
endmodule

// File: rtl/reqack_monitor.sv
`timescale 1ns/1ps
module reqack_monitor
    import reqack_pkg::*;
#(
    parameter int MIN_ACK = 1,
    parameter int MAX_ACK = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       ack,
    output logic [4:0] err_flags,
    output logic       err_pulse,
    output logic       pending
);
    logic                req_rise;
    logic [NUM_VIOL-1:0] det;
    logic [NUM_VIOL-1:0] flags_q;

    reqack_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_rise (req_rise)
    );

    reqack_fsm #(.MIN_ACK(MIN_ACK), .MAX_ACK(MAX_ACK)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .ack      (ack),
        .req_rise (req_rise),
        .det      (det),
        .pending  (pending)
    );

    reqack_collect u_collect (
        .clk     (clk),
        .rst_n   (rst_n),
        .det     (det),
        .flags_q (flags_q),
        .pulse_q (err_pulse)
    );

    assign err_flags = flags_q;

    // R5: an orphan flag only appears for a cycle with nothing outstanding
    a_r5_orphan_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[V_ORPHAN]) |-> !$past(pending));
    // R4: a repeated-request flag only appears when a request was outstanding
    a_r4_repeat_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flags[V_REPEAT]) |-> $past(pending));
endmodule

// File: tb/reqack_monitor_test.sv
`timescale 1ns/1ps
module reqack_monitor_test;
    localparam int MIN_D = 1;
    localparam int MAX_D = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic       ack = 1'b0;
    logic [4:0] err_flags;
    logic       err_pulse;
    logic       pending;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    // reference model state: 0 idle, 1 waiting, 2 acknowledged
    int         m_st = 0;
    int         m_cnt = 0;
    bit         m_reqq = 1'b0;
    logic [4:0] m_flags = '0;
    bit         m_pulse = 1'b0;

    always #2.5 clk = ~clk;

    reqack_monitor #(.MIN_ACK(MIN_D), .MAX_ACK(MAX_D)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .ack       (ack),
        .err_flags (err_flags),
        .err_pulse (err_pulse),
        .pending   (pending)
    );

    function automatic string bit_tag(input int i);
        case (i)
            0: return "R4 repeat";
            1: return "R5 orphan";
            2: return "R6 duplicate";
            3: return "R7 early";
            default: return "R8 late";
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(input bit r, input bit a);
        bit         rise = r && !m_reqq;
        logic [4:0] d = '0;
        int         ns = m_st;
        int         nc = m_cnt;
        if (m_st != 1) begin
            if (rise) begin
                if (a) begin
                    if (MIN_D > 0) d[3] = 1'b1;
                    ns = 2;
                end else begin
                    ns = 1;
                    nc = 1;
                end
            end else begin
                if (a) begin
                    if (m_st == 0) d[1] = 1'b1;
                    else           d[2] = 1'b1;
                end
                if (m_st == 2 && !r) ns = 0;
            end
        end else begin
            if (a) begin
                if (m_cnt > MAX_D)      d[4] = 1'b1;
                else if (m_cnt < MIN_D) d[3] = 1'b1;
                ns = (m_cnt > MAX_D) ? 0 : 2;
            end else if (m_cnt > MAX_D) begin
                d[4] = 1'b1;
                ns = 0;
            end else begin
                nc = m_cnt + 1;
            end
            if (rise) begin
                d[0] = 1'b1;
                ns = 1;
                nc = 1;
            end
        end
        m_flags = m_flags | d;
        m_pulse = |d;
        m_st    = ns;
        m_cnt   = nc;
        m_reqq  = r;
    endtask

    task automatic compare_all();
        for (int i = 0; i < 5; i++) chk(bit_tag(i), int'(err_flags[i]), int'(m_flags[i]));
        chk("R10 strobe", int'(err_pulse), int'(m_pulse));
        chk("R2 pending", int'(pending), (m_st == 1) ? 1 : 0);
    endtask

    task automatic step(input bit r, input bit a);
        @(negedge clk);
        req = r;
        ack = a;
        @(posedge clk);
        model_step(r, a);
        #1;
        compare_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req = 1'b0;
        ack = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 flags in reset", int'(err_flags), 0);
        chk("R1 strobe in reset", int'(err_pulse), 0);
        chk("R1 pending in reset", int'(pending), 0);
        m_st = 0; m_cnt = 0; m_reqq = 1'b0; m_flags = '0; m_pulse = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_0a17);
        do_reset();
        step(0, 0);
        chk("R1 flags after reset", int'(err_flags), 0);

        // R3: on-time acknowledge at each legal delay
        for (int d = MIN_D; d <= MAX_D; d++) begin
            step(1, 0);
            for (int k = 1; k < d; k++) step(1, 0);
            step(1, 1);
            chk("R3 no fault on time", int'(err_flags), 0);
            chk("R3 pending dropped", int'(pending), 0);
            step(0, 0);
        end

        // R7: acknowledge in the request-edge cycle is early
        step(1, 1);
        chk("R7 same-cycle early", int'(err_flags[3]), 1);
        chk("R12 strobe same edge", int'(err_pulse), 1);
        step(0, 0);
        do_reset();

        // R8: timeout, then R5 orphan while req still high
        step(1, 0);
        for (int k = 0; k < MAX_D; k++) step(1, 0);
        chk("R8 still pending before timeout", int'(pending), 1);
        step(1, 0);
        chk("R8 late flag", int'(err_flags[4]), 1);
        chk("R8 pending cleared", int'(pending), 0);
        step(1, 1);
        chk("R5 orphan flag", int'(err_flags[1]), 1);
        step(0, 0);
        step(0, 0);
        chk("R9 flags held", int'(err_flags), 5'b10010);
        chk("R10 strobe idle", int'(err_pulse), 0);
        do_reset();

        // R6: second acknowledge for one request
        step(1, 0);
        step(1, 1);
        step(1, 1);
        chk("R6 duplicate flag", int'(err_flags[2]), 1);
        step(0, 1);
        step(0, 1);
        chk("R5 orphan after release", int'(err_flags[1]), 1);
        do_reset();

        // R4 and R11: repeated request restarts timing
        step(1, 0);
        step(0, 0);
        step(1, 0);
        chk("R4 repeat flag", int'(err_flags[0]), 1);
        chk("R11 still pending", int'(pending), 1);
        step(1, 0);
        step(1, 1);
        chk("R11 on-time after restart", int'(err_flags & 5'b11000), 0);
        step(0, 0);
        do_reset();

        // constrained random traffic checked against the model
        for (int n = 0; n < 3000; n++) begin
            bit r = req;
            bit a;
            if (($urandom % 4) == 0) r = ~r;
            a = (($urandom % 5) == 0);
            if ((n % 600) == 599) do_reset();
            else step(r, a);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule